// File: doc/BRIEF.md
# Output Unit Status and Interrupt Controller

This block keeps the event bookkeeping for a streaming output unit. The datapath pulses it for four kinds of events: first buffer drained, second buffer drained, memory data arriving too late, and fill threshold reached. From these pulses the block keeps five sticky status flags. A fifth condition, underrun, is derived here: it marks a buffer-drain event that arrives while an earlier drain has not yet been acknowledged by software. Software writes a per-flag interrupt mask and clears flags by writing ones to an acknowledge port. The block drives a level-sensitive interrupt request for as long as any unmasked flag is set.

The block also holds the mode field, the overlay-enable bit and the byte-order bit. Writes go into pending registers. The datapath sees the active copies, which take the pending values only on a one-cycle boundary strobe at the start of a field or buffer. While the unit is disabled, the active copies follow the pending registers freely. A reconfiguration made in mid-stream therefore never changes the format of a buffer that is already being sent.

Top module: `ostat_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status`, `irq`, `act_mode`, `act_ovl` and `act_le` are all zero, and the interrupt mask is all zero.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge. The bit positions are: 0 = first buffer drained, 1 = second buffer drained, 2 = bandwidth error, 3 = underrun, 4 = threshold reached.
- R3: A status bit stays set until a cycle with `ack_wr` high and a 1 in the same position of `ack_bits`. Zero bits in `ack_bits` and cycles without `ack_wr` leave the flags unchanged.
- R4: When an event and an acknowledge of the same bit occur in the same cycle, the bit is set after that edge.
- R5: Status bit 3 is set when a drain event (bit 0 or bit 1 source) occurs while status bit 0 or bit 1 is already set before that edge. An acknowledge in the same cycle does not prevent this.
- R6: The interrupt mask, written with `mask_wr`/`mask_bits`, has no effect on `status`.
- R7: `irq` is high exactly when some status bit is set whose mask bit is also set. It changes on the same edge as the status or mask change that causes it.
- R8: While `unit_en` is high and `boundary` is low, `act_mode`, `act_ovl` and `act_le` hold their values, even across writes to `cfg_wr`.
- R9: On an edge with `boundary` high, or with `unit_en` low, the active copies take the most recently written configuration, including a write in that same cycle.
- R10: The bandwidth-error pulse sets only bit 2 and disturbs no other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_drain1 | input | 1 | First buffer drained (pulse) |
| ev_drain2 | input | 1 | Second buffer drained (pulse) |
| ev_late | input | 1 | Memory data arrived too late (pulse) |
| ev_level | input | 1 | Fill threshold reached (pulse) |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_bits | input | 5 | Ones clear the matching status bits |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_bits | input | 5 | New interrupt mask |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | MODE_W | Mode field to write |
| cfg_ovl | input | 1 | Overlay enable to write |
| cfg_le | input | 1 | Byte order to write |
| unit_en | input | 1 | Output unit running |
| boundary | input | 1 | Field or buffer start strobe |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Level interrupt request |
| act_mode | output | MODE_W | Active mode field |
| act_ovl | output | 1 | Active overlay enable |
| act_le | output | 1 | Active byte order |

## Verification
Every result is due one edge after its cause: `status`, `irq` and the active configuration are all registered from next-state values, so a stimulus driven before edge k shows on all outputs after edge k. The bench drives inputs on the falling edge. It advances a reference model at the rising edge from those held inputs and compares all outputs at the following falling edge, so every comparison samples exactly one edge after its stimulus. Directed cases cover same-cycle event and acknowledge, underrun with a simultaneous acknowledge, and configuration writes coinciding with a boundary or made while disabled.

// File: rtl/ostat_pkg.sv
package ostat_pkg;
  localparam int NFLAG     = 5;
  localparam int F_DRAIN1  = 0;
  localparam int F_DRAIN2  = 1;
  localparam int F_LATE    = 2;
  localparam int F_UNDER   = 3;
  localparam int F_LEVEL   = 4;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/ostat_flags.sv
module ostat_flags
  import ostat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set_ev,
  input  logic      ack_wr,
  input  flag_vec_t ack_bits,
  output flag_vec_t status_d,
  output flag_vec_t status_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic clr;
    assign clr         = ack_wr & ack_bits[i];
    assign status_d[i] = set_ev[i] | (status_q[i] & ~clr);

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_d[i];
    end

    // R2
    ev_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      set_ev[i] |=> status_q[i]);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr) |=> status_q[i]);
    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && !set_ev[i]) |=> !status_q[i]);
  end
endmodule

// File: rtl/ostat_irq.sv
module ostat_irq
  import ostat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mask_wr,
  input  flag_vec_t mask_bits,
  input  flag_vec_t status_d,
  input  flag_vec_t status_q,
  output logic      irq
);
  flag_vec_t en_q, en_d;

  assign en_d = mask_wr ? mask_bits : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= en_d;
      irq  <= |(status_d & en_d);
    end
  end

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(status_q & en_q));
endmodule

// File: rtl/ostat_shadow.sv
module ostat_shadow #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_ovl,
  input  logic              cfg_le,
  input  logic              unit_en,
  input  logic              boundary,
  output logic [MODE_W-1:0] act_mode,
  output logic              act_ovl,
  output logic              act_le
);
  localparam int CW = MODE_W + 2;

  logic [CW-1:0] pend_q, pend_d, act_q;
  logic          load;

  assign pend_d = cfg_wr ? {cfg_mode, cfg_ovl, cfg_le} : pend_q;
  assign load   = boundary | ~unit_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load) act_q <= pend_d;
    end
  end

  assign act_mode = act_q[CW-1:2];
  assign act_ovl  = act_q[1];
  assign act_le   = act_q[0];

  // R8
  hold_running_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_en && !boundary) |=> $stable(act_q));
  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!unit_en && cfg_wr) |=> (act_mode == $past(cfg_mode) && act_ovl == $past(cfg_ovl)
                              && act_le == $past(cfg_le)));
endmodule

// File: rtl/ostat_ctrl.sv
module ostat_ctrl
  import ostat_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_drain1,
  input  logic              ev_drain2,
  input  logic              ev_late,
  input  logic              ev_level,
  input  logic              ack_wr,
  input  logic [4:0]        ack_bits,
  input  logic              mask_wr,
  input  logic [4:0]        mask_bits,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_ovl,
  input  logic              cfg_le,
  input  logic              unit_en,
  input  logic              boundary,
  output logic [4:0]        status,
  output logic              irq,
  output logic [MODE_W-1:0] act_mode,
  output logic              act_ovl,
  output logic              act_le
);
  flag_vec_t set_ev, status_d, status_q;
  logic      drain_ev, drain_pending, under_ev;

  assign drain_ev      = ev_drain1 | ev_drain2;
  assign drain_pending = status_q[F_DRAIN1] | status_q[F_DRAIN2];
  assign under_ev      = drain_ev & drain_pending;

  always_comb begin
    set_ev           = '0;
    set_ev[F_DRAIN1] = ev_drain1;
    set_ev[F_DRAIN2] = ev_drain2;
    set_ev[F_LATE]   = ev_late;
    set_ev[F_UNDER]  = under_ev;
    set_ev[F_LEVEL]  = ev_level;
  end

  ostat_flags u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .ack_wr(ack_wr), .ack_bits(ack_bits),
    .status_d(status_d), .status_q(status_q)
  );

  ostat_irq u_irq (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_bits(mask_bits),
    .status_d(status_d), .status_q(status_q), .irq(irq)
  );

  ostat_shadow #(.MODE_W(MODE_W)) u_shadow (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_ovl(cfg_ovl),
    .cfg_le(cfg_le), .unit_en(unit_en), .boundary(boundary),
    .act_mode(act_mode), .act_ovl(act_ovl), .act_le(act_le)
  );

  assign status = status_q;

  // R5
  underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_drain1 || ev_drain2) && (status[F_DRAIN1] || status[F_DRAIN2])) |=> status[F_UNDER]);
  // R10
  late_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_late && !ev_drain1 && !ev_drain2 && !ev_level && !ack_wr) |=>
      (status[F_DRAIN1] == $past(status[F_DRAIN1]) && status[F_LEVEL] == $past(status[F_LEVEL])
       && status[F_UNDER] == $past(status[F_UNDER])));
endmodule

// File: tb/sim_ostat_ctrl.sv
module sim_ostat_ctrl;
  localparam int MW = 2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_drain1 = 0, ev_drain2 = 0, ev_late = 0, ev_level = 0;
  logic ack_wr = 0, mask_wr = 0, cfg_wr = 0, cfg_ovl = 0, cfg_le = 0;
  logic unit_en = 0, boundary = 0;
  logic [4:0] ack_bits = '0, mask_bits = '0;
  logic [MW-1:0] cfg_mode = '0;
  logic [4:0] status;
  logic irq, act_ovl, act_le;
  logic [MW-1:0] act_mode;

  int checks = 0, errors = 0;
  logic [4:0] m_st = '0, m_en = '0;
  logic [MW+1:0] m_pend = '0, m_act = '0;

  always #2 clk = ~clk;

  ostat_ctrl #(.MODE_W(MW)) u0 (
    .clk(clk), .rst(rst), .ev_drain1(ev_drain1), .ev_drain2(ev_drain2), .ev_late(ev_late),
    .ev_level(ev_level), .ack_wr(ack_wr), .ack_bits(ack_bits), .mask_wr(mask_wr),
    .mask_bits(mask_bits), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_ovl(cfg_ovl),
    .cfg_le(cfg_le), .unit_en(unit_en), .boundary(boundary), .status(status), .irq(irq),
    .act_mode(act_mode), .act_ovl(act_ovl), .act_le(act_le)
  );

  function automatic logic [4:0] next_status(logic [4:0] cur);
    logic [4:0] s;
    logic under;
    under = (ev_drain1 | ev_drain2) & (cur[0] | cur[1]);
    s = cur & ~(ack_wr ? ack_bits : 5'b0);
    s = s | {ev_level, under, ev_late, ev_drain2, ev_drain1};
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    ev_drain1 = 0; ev_drain2 = 0; ev_late = 0; ev_level = 0;
    ack_wr = 0; mask_wr = 0; cfg_wr = 0; boundary = 0;
  endtask

  // one edge: update model from held inputs, compare after falling edge
  task automatic step();
    logic [MW+1:0] pd;
    @(posedge clk);
    pd = cfg_wr ? {cfg_mode, cfg_ovl, cfg_le} : m_pend;
    m_st = next_status(m_st);
    if (mask_wr) m_en = mask_bits;
    if (boundary || !unit_en) m_act = pd;
    m_pend = pd;
    @(negedge clk);
    chk("R3", 32'(status), 32'(m_st));
    chk("R7", 32'(irq), 32'(|(m_st & m_en)));
    chk("R8", 32'({act_mode, act_ovl, act_le}), 32'(m_act));
    clear_pulses();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'({status, irq, act_mode, act_ovl, act_le}), 32'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", 32'({status, irq, act_mode, act_ovl, act_le}), 32'd0);

    // R2 each event sets its own bit
    ev_drain1 = 1; step(); chk("R2", 32'(status), 32'h01);
    ev_late = 1; step(); chk("R10", 32'(status), 32'h05);
    ev_level = 1; step(); chk("R2", 32'(status), 32'h15);
    // R5 drain with drain1 pending plus same-cycle ack of it
    ev_drain2 = 1; ack_wr = 1; ack_bits = 5'h01; step();
    chk("R5", 32'(status), 32'h1E);
    // R4 event and ack same cycle
    ev_level = 1; ack_wr = 1; ack_bits = 5'h1F; step();
    chk("R4", 32'(status), 32'h10);
    // R6 mask write leaves status, R7 irq rises
    mask_wr = 1; mask_bits = 5'h10; step();
    chk("R6", 32'(status), 32'h10);
    chk("R7", 32'(irq), 32'd1);
    ack_wr = 1; ack_bits = 5'h10; step();
    chk("R7", 32'(irq), 32'd0);
    // R9 disabled: follow writes
    cfg_wr = 1; cfg_mode = 2'd3; cfg_ovl = 1; cfg_le = 0; step();
    chk("R9", 32'({act_mode, act_ovl, act_le}), 32'b1110);
    // R8 running: hold across write
    unit_en = 1; cfg_wr = 1; cfg_mode = 2'd1; cfg_ovl = 0; cfg_le = 1; step();
    chk("R8", 32'({act_mode, act_ovl, act_le}), 32'b1110);
    // R9 boundary with same-cycle write
    boundary = 1; cfg_wr = 1; cfg_mode = 2'd2; cfg_ovl = 1; cfg_le = 1; step();
    chk("R9", 32'({act_mode, act_ovl, act_le}), 32'b1011);

    for (int n = 0; n < 3000; n++) begin
      ev_drain1 = ($urandom % 5) == 0;
      ev_drain2 = ($urandom % 5) == 0;
      ev_late   = ($urandom % 7) == 0;
      ev_level  = ($urandom % 6) == 0;
      ack_wr    = ($urandom % 3) == 0;
      ack_bits  = 5'($urandom);
      mask_wr   = ($urandom % 8) == 0;
      mask_bits = 5'($urandom);
      cfg_wr    = ($urandom % 4) == 0;
      cfg_mode  = MW'($urandom);
      cfg_ovl   = 1'($urandom);
      cfg_le    = 1'($urandom);
      boundary  = ($urandom % 6) == 0;
      if (($urandom % 20) == 0) unit_en = ~unit_en;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule